// File: doc/BRIEF.md
# Serial Port Interrupt Source Selector

This block produces the single interrupt request of a synchronous serial port. A function-select input picks which serial-port event raises it: the buffer-status event or the end of a data telegram. The buffer-status event is a rising edge of either "transmit buffer empty" or "receive buffer full". These serial-port events are gated by an interrupt mask and by the port's active flag.

Falling edges on the serial clock pin and on the serial data pin can also raise the request. Each pin has its own edge enable. Neither the mask nor the active flag affects them, so the pins serve as extra external interrupt lines while the port is switched off.

Every accepted event sets a sticky pending flag. The flag drives both the interrupt request and a wake request for the sleep controller. It is cleared by a one-cycle acknowledge pulse. All inputs and outputs are plain control and status pins. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `serial_irq_sel`

## Requirements
- R1: While reset is asserted and right after it is released, `irq_req` and `wake_req` are 0.
- R2: With `fn_sel`=0 (buffer status), `irq_mask`=1 and `port_active`=1, a 0-to-1 change on `tx_empty` or on `rx_full` sets the pending flag. `irq_req` is 1 one clock after the cycle in which the new level is sampled.
- R3: With `fn_sel`=1 (telegram end), a one-cycle `tgram_end` pulse sets the pending flag one clock later, and buffer-status changes are ignored. With `fn_sel`=0, `tgram_end` is ignored.
- R4: With `irq_mask`=0, neither serial-port event sets the pending flag.
- R5: With `port_active`=0, serial-port events are ignored, but enabled pin falling edges still set the pending flag.
- R6: A 1-to-0 change on an enabled pin (`pin_in[0]` is the clock pin, `pin_in[1]` is the data pin) sets the pending flag. `irq_req` goes high three clocks after the cycle in which the low level is first sampled: two synchronizer stages, then the edge register. A 0-to-1 change sets nothing.
- R7: Pin `i` raises the interrupt only when `pin_edge_en[i]`=1. `irq_mask` has no effect on pin edges.
- R8: An `irq_ack` pulse clears the pending flag on the next clock. If a new event is accepted in the same cycle as the acknowledge, the flag stays 1.
- R9: `wake_req` follows the pending flag at all times.
- R10: Without an acknowledge, the pending flag stays 1 once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_sel | input | 1 | Serial source select: 0 = buffer status, 1 = telegram end |
| irq_mask | input | 1 | 1 enables the serial-port sources |
| port_active | input | 1 | 1 while the serial port runs |
| tx_empty | input | 1 | Transmit buffer empty level |
| rx_full | input | 1 | Receive buffer full level |
| tgram_end | input | 1 | One-cycle telegram-end pulse |
| pin_in | input | 2 | Raw pin levels: bit 0 clock pin, bit 1 data pin |
| pin_edge_en | input | 2 | Per-pin falling-edge interrupt enable |
| irq_ack | input | 1 | One-cycle acknowledge, clears pending |
| irq_req | output | 1 | Interrupt request (pending flag) |
| wake_req | output | 1 | Wake request to sleep controller |

## Verification
Serial-port events appear on `irq_req` one clock after they are sampled. Pin falling edges take three clocks, and an acknowledge clears the flag after one clock. The bench drives inputs on falling clock edges and keeps a cycle-exact reference model. The model holds the same number of register stages on each path: the buffer-level history, the three-deep pin chain and the pending flag. The bench compares both outputs on the next falling edge after each clock. Directed sequences also check the exact tick at which a pin edge becomes visible. For example, the flag is still 0 after two clocks and 1 after the third.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  typedef enum logic {
    SRC_BUFFER   = 1'b0,
    SRC_TELEGRAM = 1'b1
  } irq_src_e;
endpackage

// File: rtl/pin_fall_det.sv
module pin_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  // sh[0..STAGES-1] synchronizer, sh[STAGES] previous synced value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], pin_i};
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];

  // R6: a falling edge is reported for exactly one cycle
  a_r6_fall_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/buf_event_det.sv
module buf_event_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty_i,
  input  logic rx_full_i,
  output logic evt_o
);
  logic tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= 1'b1;
      rx_q <= 1'b1;
    end else begin
      tx_q <= tx_empty_i;
      rx_q <= rx_full_i;
    end
  end

  assign evt_o = (tx_empty_i & ~tx_q) | (rx_full_i & ~rx_q);
endmodule

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (ack_i) pend_o <= 1'b0;
  end

  // R8: set wins over a simultaneous acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  // R8: acknowledge alone clears
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !pend_o);
  // R10: flag is sticky without acknowledge
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ack_i) |=> pend_o);
  // R4: no event, no new request
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !set_i) |=> !pend_o);
endmodule

// File: rtl/serial_irq_sel.sv
module serial_irq_sel
  import serial_irq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fn_sel,
  input  logic                irq_mask,
  input  logic                port_active,
  input  logic                tx_empty,
  input  logic                rx_full,
  input  logic                tgram_end,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] pin_edge_en,
  input  logic                irq_ack,
  output logic                irq_req,
  output logic                wake_req
);
  logic [NUM_PINS-1:0] pin_fall;
  logic                buf_evt;
  logic                ser_evt;
  logic                pin_evt;
  logic                set_any;
  logic                pend;
  irq_src_e            src;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in[g]),
      .fall_o (pin_fall[g])
    );
  end

  buf_event_det u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_empty_i (tx_empty),
    .rx_full_i  (rx_full),
    .evt_o      (buf_evt)
  );

  assign src = irq_src_e'(fn_sel);

  always_comb begin
    unique case (src)
      SRC_TELEGRAM: ser_evt = tgram_end;
      default:      ser_evt = buf_evt;
    endcase
  end

  assign pin_evt = |(pin_fall & pin_edge_en);
  assign set_any = (ser_evt & irq_mask & port_active) | pin_evt;

  irq_pend_flag u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_any),
    .ack_i  (irq_ack),
    .pend_o (pend)
  );

  assign irq_req  = pend;
  assign wake_req = pend;

  // R7: a disabled pin edge alone never raises the request
  a_r7_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(ser_evt & irq_mask & port_active) && ((pin_fall & pin_edge_en) == '0))
    |=> !irq_req);
endmodule

// File: tb/serial_irq_sel_tb.sv
`timescale 1ns/1ps
module serial_irq_sel_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, fn_sel, irq_mask, port_active, tx_empty, rx_full, tgram_end, irq_ack;
  logic [1:0] pin_in, pin_edge_en;
  logic irq_req, wake_req;

  serial_irq_sel u_dut (
    .clk(clk), .rst_n(rst_n), .fn_sel(fn_sel), .irq_mask(irq_mask),
    .port_active(port_active), .tx_empty(tx_empty), .rx_full(rx_full),
    .tgram_end(tgram_end), .pin_in(pin_in), .pin_edge_en(pin_edge_en),
    .irq_ack(irq_ack), .irq_req(irq_req), .wake_req(wake_req)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic m_pend, m_txq, m_rxq;
  logic [1:0] m_s1, m_s2, m_s3;

  function automatic logic ser_set(logic fn, logic msk, logic act, logic tx, logic rx,
                                   logic tg, logic txq, logic rxq);
    logic b;
    b = (tx & ~txq) | (rx & ~rxq);
    return msk & act & (fn ? tg : b);
  endfunction

  function automatic logic pin_set(logic [1:0] s2, logic [1:0] s3, logic [1:0] en);
    return |(s3 & ~s2 & en);
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: model update from pre-edge values, then compare at next falling edge
  task automatic tick(string tag);
    logic st;
    if (!rst_n) begin
      m_pend = 0; m_txq = 1; m_rxq = 1; m_s1 = '1; m_s2 = '1; m_s3 = '1;
    end else begin
      st = ser_set(fn_sel, irq_mask, port_active, tx_empty, rx_full, tgram_end, m_txq, m_rxq)
         | pin_set(m_s2, m_s3, pin_edge_en);
      m_pend = st | (m_pend & ~irq_ack);
      m_txq = tx_empty; m_rxq = rx_full;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
    @(negedge clk);
    chk(tag, irq_req, m_pend);
    chk("R9", wake_req, irq_req);
  endtask

  task automatic clear();
    irq_ack = 1; tick("R8"); irq_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fn_sel = 0; irq_mask = 1; port_active = 1; tx_empty = 0; rx_full = 0;
    tgram_end = 0; irq_ack = 0; pin_in = '1; pin_edge_en = '0;
    @(negedge clk);
    tick("R1"); tick("R1");
    chk("R1", irq_req, 1'b0); chk("R1", wake_req, 1'b0);
    rst_n = 1;
    tick("R1"); chk("R1", irq_req, 1'b0);

    // R2 buffer status
    tx_empty = 1; tick("R2"); chk("R2", irq_req, 1'b1); chk("R9", wake_req, 1'b1);
    tick("R10"); tick("R10"); chk("R10", irq_req, 1'b1);
    clear(); chk("R8", irq_req, 1'b0);
    rx_full = 1; tick("R2"); chk("R2", irq_req, 1'b1);
    clear(); tx_empty = 0; rx_full = 0; tick("R2");

    // R3 telegram end select
    fn_sel = 1; tx_empty = 1; tick("R3"); chk("R3", irq_req, 1'b0);
    tgram_end = 1; tick("R3"); tgram_end = 0; chk("R3", irq_req, 1'b1);
    clear();
    fn_sel = 0; tx_empty = 0; tick("R3");
    tgram_end = 1; tick("R3"); tgram_end = 0; chk("R3", irq_req, 1'b0);

    // R4 mask
    irq_mask = 0; tx_empty = 1; tick("R4"); chk("R4", irq_req, 1'b0);
    fn_sel = 1; tgram_end = 1; tick("R4"); tgram_end = 0; chk("R4", irq_req, 1'b0);
    irq_mask = 1;

    // R5 port inactive, pin still works
    port_active = 0; tgram_end = 1; tick("R5"); tgram_end = 0; chk("R5", irq_req, 1'b0);
    pin_edge_en = 2'b01; pin_in[0] = 0;
    tick("R6"); tick("R6"); chk("R6", irq_req, 1'b0);
    tick("R5"); chk("R5", irq_req, 1'b1);
    clear();
    pin_in[0] = 1; repeat (4) tick("R6"); chk("R6", irq_req, 1'b0);

    // R7 per-pin enable, mask has no effect on pins
    pin_in[1] = 0; repeat (4) tick("R7"); chk("R7", irq_req, 1'b0);
    pin_in[1] = 1; repeat (3) tick("R7");
    irq_mask = 0; pin_edge_en = 2'b10; pin_in[1] = 0; repeat (3) tick("R7");
    chk("R7", irq_req, 1'b1);
    clear(); pin_in[1] = 1; irq_mask = 1; port_active = 1; repeat (3) tick("R7");

    // R8 ack with simultaneous event
    tgram_end = 1; tick("R8"); chk("R8", irq_req, 1'b1);
    irq_ack = 1; tick("R8"); chk("R8", irq_req, 1'b1);
    tgram_end = 0; tick("R8"); irq_ack = 0; chk("R8", irq_req, 1'b0);

    // constrained random against the model
    void'($urandom(32'h1bad5eed));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) fn_sel = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) irq_mask = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) port_active = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0)  pin_edge_en = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0)  tx_empty = ~tx_empty;
      if ($urandom_range(0, 3) == 0)  rx_full = ~rx_full;
      if ($urandom_range(0, 2) == 0)  pin_in = 2'($urandom_range(0, 3));
      tgram_end = ($urandom_range(0, 7) == 0);
      irq_ack = ($urandom_range(0, 3) == 0);
      tick("R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule